// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous memory of 32-bit words with a pipelined bus that has no dead cycles when it switches direction. Address, control and byte enables are registered on the rising clock edge. The data phase of every command comes exactly two accepted edges after its command edge. A read places its word on the data output then, and a write takes its data from the data input then. Because both directions share the same latency, a write may follow a read, or a read a write, on every cycle.

A command is either a load or an advance. A load takes a new external address and a new read/write choice. An advance steps the two low address bits of the current burst, wrapping linearly, and repeats the loaded operation type. Three chip enables select the part. A clock enable can freeze the whole pipeline. An active-low output enable gates the read data onto the bus without a register stage. The depth is 2^`ADDR_W` words. `ADDR_W` = 16 gives the full 65,536-word array, and the default of 10 keeps elaboration small. Data in, data out and the drive indication are separate ports.

Top module: `zsram_top`

## Requirements
- R1: When `cen_ni` is high at a rising edge, that edge has no effect. The command pipeline, the memory, the output word `dq_o` and the drive state all keep their values. Everything below counts only accepted edges, which are edges with `cen_ni` low.
- R2: A read loaded at accepted edge k makes `dq_o` show the addressed word right after accepted edge k+2.
- R3: A write loaded at accepted edge k stores the value on `dq_i` sampled at accepted edge k+2.
- R4: Reads and writes may alternate on consecutive edges. A read loaded on the edge right after a write to the same address returns the newly written data, merged under that write's byte enables.
- R5: `bw_ni[i]` low enables byte lane i, which is bits 8i+7:8i. Lanes whose enable is high keep their old contents. With all four enables low, the whole word is written.
- R6: The part is selected when `ce1_ni` is low, `ce2_i` is high and `ce3_ni` is low. A load while the part is unselected is a deselect, and `dq_oe_o` is low after accepted edge k+2.
- R7: `dq_oe_o` is high only while `oe_ni` is low and the output register holds read data. `oe_ni` acts combinationally, in the same cycle.
- R8: With `adv_i` high, the burst address becomes the previous address with its two low bits incremented modulo 4, and the upper bits are kept. The operation type and the select state come from the last load, so `we_ni` and the chip enables are ignored. `bw_ni` is sampled on every edge.
- R9: While `rst_ni` is low and after it is released, the pipeline is empty and `dq_oe_o` is low.

Load encoding: `adv_i` low with `we_ni` low is a write, and `adv_i` low with `we_ni` high is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cen_ni | input | 1 | Clock enable, active low |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load new command |
| we_ni | input | 1 | On a load: 0 = write, 1 = read |
| bw_ni | input | 4 | Byte-lane write enables, active low |
| addr_i | input | ADDR_W | Word address |
| oe_ni | input | 1 | Output enable, active low, combinational |
| dq_i | input | 32 | Write data, sampled two accepted edges after its command |
| dq_o | output | 32 | Read data |
| dq_oe_o | output | 1 | Bus drive indication for `dq_o` |

## Verification
Each command's result is due after the second accepted edge that follows it. Read data and the drive state then show at the outputs, and write data is taken from `dq_i` at that edge. The vector table encodes this directly. Inputs for row k are applied on the falling edge, and the outputs are checked on the next falling edge against the result of row k-2. The write data for row k sits in row k+2. The clock-enable test counts only the edges on which `cen_ni` is low, and it also confirms that the output holds through a frozen edge.

// File: rtl/zsram_pkg.sv
package zsram_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned LANES   = DATA_W / LANE_W;
  localparam int unsigned BURST_W = 2;

  typedef struct packed {
    logic             act;
    logic             wr;
    logic [LANES-1:0] be_n;
  } op_t;
endpackage

// File: rtl/zsram_cmd.sv
module zsram_cmd
  import zsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              adv_i,
  input  logic              sel_i,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output op_t               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  op_t               op_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= '0;
      addr_q <= '0;
    end else if (en_i) begin
      if (adv_i) begin
        // burst step: keep op type and select, wrap low bits
        op_q.be_n             <= bw_ni;
        addr_q[BURST_W-1:0]   <= addr_q[BURST_W-1:0] + 1'b1;
      end else begin
        op_q.act  <= sel_i;
        op_q.wr   <= sel_i & ~we_ni;
        op_q.be_n <= bw_ni;
        addr_q    <= addr_i;
      end
    end
  end

  assign op_o   = op_q;
  assign addr_o = addr_q;

  // R1
  cmd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(op_q) && $stable(addr_q)));

  // R8
  burst_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && adv_i) |=> ((addr_q[BURST_W-1:0] == BURST_W'($past(addr_q[BURST_W-1:0]) + 1'b1))
                         && $stable(op_q.act) && $stable(op_q.wr)
                         && $stable(addr_q[ADDR_W-1:BURST_W])));
endmodule

// File: rtl/zsram_stage.sv
module zsram_stage
  import zsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  op_t               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_t               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_o   <= '0;
      addr_o <= '0;
    end else if (en_i) begin
      op_o   <= op_i;
      addr_o <= addr_i;
    end
  end
endmodule

// File: rtl/zsram_core.sv
module zsram_core
  import zsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  op_t               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvld_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              rvld_q;
  logic              do_wr, do_rd;

  assign do_wr = en_i & op_i.act & op_i.wr;
  assign do_rd = en_i & op_i.act & ~op_i.wr;

  always_ff @(posedge clk_i) begin
    if (do_wr) begin
      for (int b = 0; b < int'(LANES); b++) begin
        if (!op_i.be_n[b]) mem_q[addr_i][b*LANE_W +: LANE_W] <= wdata_i[b*LANE_W +: LANE_W];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else if (en_i) begin
      rvld_q <= do_rd;
      if (do_rd) rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;
  assign rvld_o  = rvld_q;

  // R1
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(rdata_q) && $stable(rvld_q)));

  // R6
  drive_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rvld_q) |-> $past(op_i.act && !op_i.wr));
endmodule

// File: rtl/zsram_top.sv
module zsram_top
  import zsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic [3:0]        bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              oe_ni,
  input  logic [31:0]       dq_i,
  output logic [31:0]       dq_o,
  output logic              dq_oe_o
);
  logic              en, sel, rvld;
  op_t               op_s1, op_s2;
  logic [ADDR_W-1:0] addr_s1, addr_s2;

  assign en  = ~cen_ni;
  assign sel = ~ce1_ni & ce2_i & ~ce3_ni;

  zsram_cmd #(.ADDR_W(ADDR_W)) u_cmd (
    .clk_i, .rst_ni, .en_i(en), .adv_i, .sel_i(sel), .we_ni, .bw_ni, .addr_i,
    .op_o(op_s1), .addr_o(addr_s1)
  );

  zsram_stage #(.ADDR_W(ADDR_W)) u_stage (
    .clk_i, .rst_ni, .en_i(en), .op_i(op_s1), .addr_i(addr_s1),
    .op_o(op_s2), .addr_o(addr_s2)
  );

  zsram_core #(.ADDR_W(ADDR_W)) u_core (
    .clk_i, .rst_ni, .en_i(en), .op_i(op_s2), .addr_i(addr_s2), .wdata_i(dq_i),
    .rdata_o(dq_o), .rvld_o(rvld)
  );

  assign dq_oe_o = rvld & ~oe_ni;
endmodule

// File: tb/tb_zsram_top.sv
module tb_zsram_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cen_ni = 1'b0, ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic        adv_i = 1'b0, we_ni = 1'b1, oe_ni = 1'b1;
  logic [3:0]  bw_ni = 4'hf;
  logic [9:0]  addr_i = '0;
  logic [31:0] dq_i = '0;
  logic [31:0] dq_o;
  logic        dq_oe_o;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  zsram_top dut (.*);

  typedef struct packed {
    logic        adv, wr, sel;
    logic [3:0]  bw;
    logic [15:0] addr;
    logic        oen;
    logic [31:0] din;
    logic        eoe;
    logic [31:0] edq;
    logic [3:0]  req;
  } vec_t;

  // expectations of row k belong to the command of row k-2; din of row k feeds the write of row k-2
  localparam vec_t VEC [21] = '{
    '{1'b0,1'b1,1'b1,4'h0,16'h010,1'b1,32'h0,       1'b0,32'h0,       4'd3}, // R3 write 010
    '{1'b0,1'b1,1'b1,4'h0,16'h011,1'b1,32'h0,       1'b0,32'h0,       4'd3},
    '{1'b0,1'b0,1'b1,4'hf,16'h010,1'b1,32'h11111111,1'b0,32'h0,       4'd3},
    '{1'b0,1'b1,1'b1,4'he,16'h011,1'b1,32'h22222222,1'b0,32'h0,       4'd5}, // R5 lane 0 only
    '{1'b0,1'b0,1'b1,4'hf,16'h011,1'b0,32'h0,       1'b1,32'h11111111,4'd2}, // R2
    '{1'b0,1'b0,1'b1,4'hf,16'h011,1'b0,32'h333333aa,1'b0,32'h0,       4'd4}, // R4 no turnaround
    '{1'b0,1'b0,1'b0,4'hf,16'h000,1'b0,32'h0,       1'b1,32'h222222aa,4'd4}, // R4 R5 merge
    '{1'b0,1'b0,1'b1,4'hf,16'h010,1'b1,32'h0,       1'b0,32'h0,       4'd7}, // R7 oe high
    '{1'b0,1'b0,1'b0,4'hf,16'h000,1'b0,32'h0,       1'b0,32'h0,       4'd6}, // R6 deselect
    '{1'b0,1'b0,1'b0,4'hf,16'h000,1'b0,32'h0,       1'b1,32'h11111111,4'd2},
    '{1'b0,1'b1,1'b1,4'h0,16'h014,1'b0,32'h0,       1'b0,32'h0,       4'd6},
    '{1'b1,1'b1,1'b1,4'h0,16'h000,1'b0,32'h0,       1'b0,32'h0,       4'd3}, // R8 burst write
    '{1'b1,1'b1,1'b1,4'h0,16'h000,1'b0,32'h0000a014,1'b0,32'h0,       4'd3},
    '{1'b1,1'b1,1'b1,4'h0,16'h000,1'b0,32'h0000a015,1'b0,32'h0,       4'd3},
    '{1'b0,1'b0,1'b1,4'hf,16'h016,1'b0,32'h0000a016,1'b0,32'h0,       4'd3},
    '{1'b1,1'b1,1'b1,4'h0,16'h123,1'b0,32'h0000a017,1'b0,32'h0,       4'd8}, // R8 we/addr ignored
    '{1'b1,1'b1,1'b0,4'h0,16'h000,1'b0,32'h0,       1'b1,32'h0000a016,4'd8}, // R8 ce ignored
    '{1'b1,1'b0,1'b0,4'hf,16'h000,1'b0,32'h0,       1'b1,32'h0000a017,4'd8},
    '{1'b0,1'b0,1'b0,4'hf,16'h000,1'b0,32'h0,       1'b1,32'h0000a014,4'd8}, // R8 wrap
    '{1'b0,1'b0,1'b0,4'hf,16'h000,1'b0,32'h0,       1'b1,32'h0000a015,4'd8},
    '{1'b0,1'b0,1'b0,4'hf,16'h000,1'b0,32'h0,       1'b0,32'h0,       4'd6}
  };

  task automatic chk(input logic eoe, input logic [31:0] edq, input int req);
    total++;
    if (dq_oe_o !== eoe) begin
      bad++;
      $display("FAIL R%0d dq_oe_o actual=%b expected=%b", req, dq_oe_o, eoe);
    end
    if (eoe) begin
      total++;
      if (dq_o !== edq) begin
        bad++;
        $display("FAIL R%0d dq_o actual=%h expected=%h", req, dq_o, edq);
      end
    end
  endtask

  task automatic put(input logic adv, input logic wr, input logic sel, input logic [3:0] bw,
                     input logic [15:0] addr, input logic oen, input logic [31:0] din, input logic cen);
    adv_i  = adv;
    we_ni  = ~wr;
    ce1_ni = ~sel;
    ce2_i  = sel;
    ce3_ni = ~sel;
    bw_ni  = bw;
    addr_i = addr[9:0];
    oe_ni  = oen;
    dq_i   = din;
    cen_ni = cen;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R9 reset state
    put(1'b0, 1'b0, 1'b0, 4'hf, 16'h0, 1'b0, 32'h0, 1'b0);
    repeat (3) @(negedge clk_i);
    chk(1'b0, 32'h0, 9);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(1'b0, 32'h0, 9);

    for (int k = 0; k < 21; k++) begin
      put(VEC[k].adv, VEC[k].wr, VEC[k].sel, VEC[k].bw, VEC[k].addr, VEC[k].oen, VEC[k].din, 1'b0);
      @(negedge clk_i);
      chk(VEC[k].eoe, VEC[k].edq, int'(VEC[k].req));
    end

    // R1: a read of 010 with two frozen edges between command and data
    put(1'b0, 1'b0, 1'b1, 4'hf, 16'h010, 1'b0, 32'h0, 1'b0);
    @(negedge clk_i); chk(1'b0, 32'h0, 1);
    put(1'b0, 1'b1, 1'b1, 4'h0, 16'h011, 1'b0, 32'hdeadbeef, 1'b1);
    @(negedge clk_i); chk(1'b0, 32'h0, 1);
    @(negedge clk_i); chk(1'b0, 32'h0, 1);
    put(1'b0, 1'b0, 1'b0, 4'hf, 16'h0, 1'b0, 32'h0, 1'b0);
    @(negedge clk_i); chk(1'b0, 32'h0, 1);
    @(negedge clk_i); chk(1'b1, 32'h11111111, 1);
    put(1'b0, 1'b0, 1'b0, 4'hf, 16'h0, 1'b0, 32'h0, 1'b1);
    @(negedge clk_i); chk(1'b1, 32'h11111111, 1); // R1 output held through frozen edge
    put(1'b0, 1'b0, 1'b0, 4'hf, 16'h0, 1'b0, 32'h0, 1'b0);
    @(negedge clk_i); chk(1'b0, 32'h0, 6);
    // R1: frozen write did not touch 011
    put(1'b0, 1'b0, 1'b1, 4'hf, 16'h011, 1'b0, 32'h0, 1'b0);
    @(negedge clk_i);
    put(1'b0, 1'b0, 1'b0, 4'hf, 16'h0, 1'b0, 32'h0, 1'b0);
    @(negedge clk_i);
    @(negedge clk_i); chk(1'b1, 32'h222222aa, 1);

    // R9 reset mid-run clears the drive state
    rst_ni = 1'b0;
    @(negedge clk_i); chk(1'b0, 32'h0, 9);
    rst_ni = 1'b1;
    @(negedge clk_i); chk(1'b0, 32'h0, 9);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule